// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on the switch side of a 16-bit host register bus and lets the host reach registers inside a small set of internal PHYs. There are two steps to an access. First the host writes a direction flag to a control register. It then issues one bus write to a specially encoded address. That address names a single PHY with a one-hot select field, a page and a register number. In write mode the bridge forwards the data word of that bus write to the PHY register. In read mode it ignores the data word, fetches the selected register and keeps the result in a read-data register. The host reads that register afterwards.

The encoded write is posted. The bridge acknowledges it at once and then runs the PHY transaction on a simple request/ready port. While that transaction is outstanding, the bridge holds back the acknowledge of every further host access. A host that reads the data register straight after a read trigger is therefore stalled until the fetched value is in place. Encoded addresses that break the pattern are acknowledged and then dropped.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, `hst_ack` and `phy_req` are low, the direction is write mode, and host reads of address 0x8028 and of address 0x8029 both return 0.
- R2: A host write to 0x8028 stores bit 0 of the data as the direction (1 = read, 0 = write). A host read of 0x8028 returns that bit in bit 0, with all other bits 0.
- R3: In write mode, a host write to a valid encoded address starts exactly one PHY transaction with `phy_we`=1. In that transaction, `phy_sel` has only bit n set, `phy_page` equals address bits 7:5, `phy_reg` equals address bits 4:0, and `phy_wdata` equals the bus data. A valid encoded address has bit 15 set, bit 14 clear, bit 8 clear, and exactly one of bits 13:9 set, where bit 9+n selects PHY n for n = 0 to 4.
- R4: In read mode, a host write to a valid encoded address starts one PHY transaction with `phy_we`=0 and `phy_wdata`=0, so the bus data is ignored. When that transaction completes, `phy_rdata` is captured, and later host reads of 0x8029 return it.
- R5: A host write to an encoded-style address that breaks the pattern is acknowledged and starts no PHY transaction. This covers no select bit set, two select bits set, bit 8 set, bit 14 set, and bit 15 clear.
- R6: `phy_req` stays high, with `phy_we`, `phy_sel`, `phy_page`, `phy_reg` and `phy_wdata` unchanged, until a clock edge at which `phy_ready` is high. It is low in the next cycle.
- R7: While a PHY transaction is outstanding, no host access is acknowledged. A read of 0x8029 issued right after a read trigger is acknowledged only after the PHY completes, and it returns the newly fetched value.
- R8: The read-data register changes only when a PHY read completes. Write-mode transactions, ignored encoded addresses and host writes to 0x8029 leave it unchanged.
- R9: Each accepted host access gets a `hst_ack` pulse one cycle wide. The pulse comes one cycle after acceptance, with `hst_rdata` valid in that same cycle. Reads of any other address, including host reads of encoded addresses, return 0 and start no transaction. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access request, held until `hst_ack` |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | 16 | Host register address |
| hst_wdata | input | 16 | Host write data |
| hst_ack | output | 1 | One-cycle acknowledge; withheld while a PHY transaction is outstanding |
| hst_rdata | output | 16 | Host read data, valid with `hst_ack` |
| phy_req | output | 1 | PHY register transaction request |
| phy_we | output | 1 | PHY transaction is a write |
| phy_sel | output | 5 | One-hot PHY select |
| phy_page | output | 3 | PHY register page |
| phy_reg | output | 5 | PHY register number |
| phy_wdata | output | 16 | PHY write data |
| phy_ready | input | 1 | PHY completes the transaction at this edge |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ready` |

## Verification
The bench builds the bridge with its default parameters. These give five PHYs, a select field that starts at bit 9, and 16-bit data. With five PHYs, address bit 14 is the out-of-range select, so it can be tested as an ignored pattern alongside the bit-8 gap. The bench's PHY model has a latency that can be set per test. Latencies of one cycle and of five to eight cycles make both the back-to-back case and the long-stall case reachable. A behavioural model of the pending transaction is compared with `phy_req` on every clock.

// File: rtl/phyb_pkg.sv
package phyb_pkg;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CTRL = 2'd1,
    HIT_DATA = 2'd2,
    HIT_PHY  = 2'd3
  } hit_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_WAIT = 1'b1
  } eng_state_e;

endpackage

// File: rtl/phyb_addr_decode.sv
module phyb_addr_decode
  import phyb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_PHY   = 5,
  parameter int PAGE_W    = 3,
  parameter int REGA_W    = 5,
  parameter int SEL_LSB   = 9,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
  input  logic [ADDR_W-1:0]  addr,
  output hit_e               hit,
  output logic [NUM_PHY-1:0] sel,
  output logic [PAGE_W-1:0]  page,
  output logic [REGA_W-1:0]  rega
);
  // select span runs from SEL_LSB up to the bit below the marker bit
  localparam int SPAN_W = ADDR_W - 1 - SEL_LSB;
  localparam int GAP_W  = SEL_LSB - PAGE_W - REGA_W;

  logic [SPAN_W-1:0] span;
  logic              gap_clear;
  logic              span_hi_clear;
  logic              one_sel;
  logic              enc_ok;

  assign span = addr[ADDR_W-2:SEL_LSB];
  assign rega = addr[REGA_W-1:0];
  assign page = addr[REGA_W+PAGE_W-1:REGA_W];
  assign sel  = span[NUM_PHY-1:0];

  generate
    if (GAP_W > 0) begin : g_gap
      assign gap_clear = (addr[SEL_LSB-1:REGA_W+PAGE_W] == '0);
    end else begin : g_nogap
      assign gap_clear = 1'b1;
    end
    if (SPAN_W > NUM_PHY) begin : g_hi
      assign span_hi_clear = (span[SPAN_W-1:NUM_PHY] == '0);
    end else begin : g_nohi
      assign span_hi_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (sel[i]) cnt = cnt + 1;
    end
    one_sel = (cnt == 1);
  end

  assign enc_ok = addr[ADDR_W-1] && gap_clear && span_hi_clear && one_sel;

  always_comb begin
    if (addr == CTRL_ADDR)      hit = HIT_CTRL;
    else if (addr == DATA_ADDR) hit = HIT_DATA;
    else if (enc_ok)            hit = HIT_PHY;
    else                        hit = HIT_NONE;
  end

endmodule

// File: rtl/phyb_host_port.sv
module phyb_host_port
  import phyb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic [DATA_W-1:0] hst_wdata,
  input  hit_e              hit,
  input  logic              busy,
  input  logic [DATA_W-1:0] data_q,
  output logic              hst_ack,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              dir_rd,
  output logic              launch
);
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              dir_q;
  logic              accept;
  logic [DATA_W-1:0] rd_mux;

  // a request is taken only once per handshake and never while the PHY side is busy
  assign accept = hst_req && !ack_q && !busy;
  assign launch = accept && hst_we && (hit == HIT_PHY);

  always_comb begin
    rd_mux = '0;
    if (!hst_we) begin
      case (hit)
        HIT_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, dir_q};
        HIT_DATA: rd_mux = data_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      dir_q   <= 1'b0;
    end else begin
      ack_q <= accept;
      if (accept) begin
        rdata_q <= rd_mux;
        if (hst_we && hit == HIT_CTRL) dir_q <= hst_wdata[0];
      end
    end
  end

  assign hst_ack   = ack_q;
  assign hst_rdata = rdata_q;
  assign dir_rd    = dir_q;

  // R9: acknowledge is a single-cycle pulse
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    hst_ack |=> !hst_ack);

  // R7: an access pending on the PHY side blocks the next acknowledge
  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !hst_ack);

endmodule

// File: rtl/phyb_phy_engine.sv
module phyb_phy_engine
  import phyb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_PHY = 5,
  parameter int PAGE_W  = 3,
  parameter int REGA_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               dir_rd,
  input  logic [NUM_PHY-1:0] sel_in,
  input  logic [PAGE_W-1:0]  page_in,
  input  logic [REGA_W-1:0]  rega_in,
  input  logic [DATA_W-1:0]  wdata_in,
  input  logic               phy_ready,
  input  logic [DATA_W-1:0]  phy_rdata,
  output logic               phy_req,
  output logic               phy_we,
  output logic [NUM_PHY-1:0] phy_sel,
  output logic [PAGE_W-1:0]  phy_page,
  output logic [REGA_W-1:0]  phy_reg,
  output logic [DATA_W-1:0]  phy_wdata,
  output logic [DATA_W-1:0]  data_q,
  output logic               busy
);
  eng_state_e        state_q;
  logic              we_q;
  logic [NUM_PHY-1:0] sel_q;
  logic [PAGE_W-1:0] page_q;
  logic [REGA_W-1:0] rega_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  logic              done;

  assign done = (state_q == ENG_WAIT) && phy_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      we_q    <= 1'b0;
      sel_q   <= '0;
      page_q  <= '0;
      rega_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (launch) begin
            state_q <= ENG_WAIT;
            we_q    <= !dir_rd;
            sel_q   <= sel_in;
            page_q  <= page_in;
            rega_q  <= rega_in;
            wd_q    <= dir_rd ? '0 : wdata_in;
          end
        end
        ENG_WAIT: begin
          if (done) begin
            state_q <= ENG_IDLE;
            if (!we_q) rd_q <= phy_rdata;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign phy_req   = (state_q == ENG_WAIT);
  assign phy_we    = we_q;
  assign phy_sel   = sel_q;
  assign phy_page  = page_q;
  assign phy_reg   = rega_q;
  assign phy_wdata = wd_q;
  assign data_q    = rd_q;
  assign busy      = (state_q == ENG_WAIT);

  // R6: request and its fields hold until the PHY answers
  p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ready) |=> (phy_req && $stable(phy_we) && $stable(phy_sel)
      && $stable(phy_page) && $stable(phy_reg) && $stable(phy_wdata)));

  // R6: request drops the cycle after completion
  p_drop_after_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_ready) |=> !phy_req);

  // R3: exactly one PHY selected during a transaction
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> ($countones(phy_sel) == 1));

  // R4: read transactions carry no host data
  p_read_no_data_r4: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_we) |-> (phy_wdata == '0));

  // R8: read-data register moves only on a completed PHY read
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(phy_req && phy_ready && !phy_we) |=> $stable(data_q));

endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phyb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_PHY = 5,
  parameter int PAGE_W  = 3,
  parameter int REGA_W  = 5,
  parameter int SEL_LSB = 9,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_req,
  input  logic               hst_we,
  input  logic [ADDR_W-1:0]  hst_addr,
  input  logic [DATA_W-1:0]  hst_wdata,
  output logic               hst_ack,
  output logic [DATA_W-1:0]  hst_rdata,
  output logic               phy_req,
  output logic               phy_we,
  output logic [NUM_PHY-1:0] phy_sel,
  output logic [PAGE_W-1:0]  phy_page,
  output logic [REGA_W-1:0]  phy_reg,
  output logic [DATA_W-1:0]  phy_wdata,
  input  logic               phy_ready,
  input  logic [DATA_W-1:0]  phy_rdata
);
  hit_e               hit;
  logic [NUM_PHY-1:0] dec_sel;
  logic [PAGE_W-1:0]  dec_page;
  logic [REGA_W-1:0]  dec_rega;
  logic               busy;
  logic               dir_rd;
  logic               launch;
  logic [DATA_W-1:0]  data_q;

  phyb_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PHY(NUM_PHY), .PAGE_W(PAGE_W), .REGA_W(REGA_W),
    .SEL_LSB(SEL_LSB), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr (hst_addr),
    .hit  (hit),
    .sel  (dec_sel),
    .page (dec_page),
    .rega (dec_rega)
  );

  phyb_host_port #(.DATA_W(DATA_W)) u_host (
    .clk       (clk),
    .rst       (rst),
    .hst_req   (hst_req),
    .hst_we    (hst_we),
    .hst_wdata (hst_wdata),
    .hit       (hit),
    .busy      (busy),
    .data_q    (data_q),
    .hst_ack   (hst_ack),
    .hst_rdata (hst_rdata),
    .dir_rd    (dir_rd),
    .launch    (launch)
  );

  phyb_phy_engine #(
    .DATA_W(DATA_W), .NUM_PHY(NUM_PHY), .PAGE_W(PAGE_W), .REGA_W(REGA_W)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .dir_rd    (dir_rd),
    .sel_in    (dec_sel),
    .page_in   (dec_page),
    .rega_in   (dec_rega),
    .wdata_in  (hst_wdata),
    .phy_ready (phy_ready),
    .phy_rdata (phy_rdata),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_sel   (phy_sel),
    .phy_page  (phy_page),
    .phy_reg   (phy_reg),
    .phy_wdata (phy_wdata),
    .data_q    (data_q),
    .busy      (busy)
  );

endmodule

// File: tb/phy_reg_bridge_tb_top.sv
module phy_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CTRL = 16'h8028;
  localparam logic [15:0] A_DATA = 16'h8029;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_req = 1'b0;
  logic        hst_we = 1'b0;
  logic [15:0] hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic        hst_ack;
  logic [15:0] hst_rdata;
  logic        phy_req;
  logic        phy_we;
  logic [4:0]  phy_sel;
  logic [2:0]  phy_page;
  logic [4:0]  phy_reg;
  logic [15:0] phy_wdata;
  logic        ready_drv = 1'b0;
  logic [15:0] rdata_drv = '0;

  int n_checks = 0;
  int n_fail = 0;
  int lat = 1;
  int cnt = 0;
  int txn_count = 0;
  int clk_errs = 0;
  bit txn_bad = 0;
  bit exp_pending = 0;
  bit live = 0;
  bit ref_dir = 0;
  logic [15:0] ref_data = '0;
  logic        exp_we;
  logic [4:0]  exp_sel;
  logic [2:0]  exp_page;
  logic [4:0]  exp_reg;
  logic [15:0] exp_wd;
  logic [15:0] phy_mem [0:4][0:7][0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_reg_bridge dut_i (
    .clk(clk), .rst(rst), .hst_req(hst_req), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_ack(hst_ack),
    .hst_rdata(hst_rdata), .phy_req(phy_req), .phy_we(phy_we),
    .phy_sel(phy_sel), .phy_page(phy_page), .phy_reg(phy_reg),
    .phy_wdata(phy_wdata), .phy_ready(ready_drv), .phy_rdata(rdata_drv)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] enc(input int n, input int p, input int r);
    return 16'h8000 | (16'h0001 << (9 + n)) | 16'((p & 7) << 5) | 16'(r & 31);
  endfunction

  function automatic bit ref_valid(input logic [15:0] a);
    int ones = 0;
    for (int i = 9; i <= 13; i++) if (a[i]) ones++;
    return a[15] && !a[14] && !a[8] && (ones == 1);
  endfunction

  function automatic int sel_idx(input logic [4:0] s);
    for (int i = 0; i < 5; i++) if (s[i]) return i;
    return 0;
  endfunction

  // PHY model and per-cycle reference of the pending transaction
  always @(negedge clk) begin
    if (ready_drv) begin
      ready_drv = 1'b0;
      exp_pending = 0;
      cnt = 0;
    end else if (phy_req === 1'b1) begin
      if ({phy_we, phy_sel, phy_page, phy_reg, phy_wdata} !==
          {exp_we, exp_sel, exp_page, exp_reg, exp_wd}) txn_bad = 1;
      cnt++;
      if (cnt >= lat) begin
        ready_drv = 1'b1;
        if (phy_we) phy_mem[sel_idx(phy_sel)][phy_page][phy_reg] = phy_wdata;
        else begin
          rdata_drv = phy_mem[sel_idx(phy_sel)][phy_page][phy_reg];
          ref_data = rdata_drv;
        end
        txn_count++;
        check(!txn_bad, "R3/R4/R6 phy fields", {phy_we, phy_sel, phy_page, phy_reg, phy_wdata[15:0]},
              {exp_we, exp_sel, exp_page, exp_reg, exp_wd});
        txn_bad = 0;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (live && (phy_req !== exp_pending)) begin
      clk_errs++;
      $display("FAIL R5/R6 per-cycle phy_req: actual %b expected %b", phy_req, exp_pending);
    end
  end

  task automatic idle_wait();
    while (exp_pending) @(negedge clk);
  endtask

  task automatic bus(input logic we, input logic [15:0] addr, input logic [15:0] wd,
                     output logic [15:0] rd, output int waits);
    bit v;
    v = we && ref_valid(addr);
    if (v) begin
      idle_wait();
      exp_we = !ref_dir;
      exp_sel = addr[13:9];
      exp_page = addr[7:5];
      exp_reg = addr[4:0];
      exp_wd = ref_dir ? 16'h0 : wd;
    end
    hst_req = 1'b1; hst_we = we; hst_addr = addr; hst_wdata = wd;
    waits = 0;
    forever begin
      @(negedge clk);
      if (hst_ack) break;
      waits++;
      if (waits > 1000) break;
    end
    rd = hst_rdata;
    check(!exp_pending, "R7 ack while PHY pending", {31'd0, exp_pending}, 32'd0);
    if (v) exp_pending = 1;
    if (we && addr == A_CTRL) ref_dir = wd[0];
    hst_req = 1'b0;
  endtask

  task automatic finish_run();
    check(clk_errs == 0, "R5/R6 per-cycle model", clk_errs, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int w;
    int t0;
    for (int n = 0; n < 5; n++)
      for (int p = 0; p < 8; p++)
        for (int r = 0; r < 32; r++)
          phy_mem[n][p][r] = 16'(n * 16'h1111) ^ 16'(p * 16'h0203) ^ 16'(r * 16'h0041) ^ 16'h5A00;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    // R1 reset state
    check(hst_ack == 1'b0 && phy_req == 1'b0, "R1 ack/req after reset", {hst_ack, phy_req}, 0);
    bus(0, A_CTRL, 0, rd, w); check(rd == 0, "R1 ctrl reset value", rd, 0);
    bus(0, A_DATA, 0, rd, w); check(rd == 0, "R1 data reset value", rd, 0);

    // R2 direction register
    bus(1, A_CTRL, 16'h0001, rd, w);
    bus(0, A_CTRL, 0, rd, w); check(rd == 16'h0001, "R2 ctrl read after 1", rd, 1);
    bus(1, A_CTRL, 16'hFFFE, rd, w);
    bus(0, A_CTRL, 0, rd, w); check(rd == 16'h0000, "R2 ctrl only bit0", rd, 0);

    // R3 write mode, corners of phy/page/reg
    lat = 1;
    bus(1, enc(0, 0, 0), 16'h1234, rd, w);
    bus(1, enc(4, 7, 31), 16'hBEEF, rd, w);
    bus(1, enc(2, 3, 17), 16'h0F0F, rd, w);
    idle_wait(); repeat (2) @(negedge clk);
    check(txn_count == 3, "R3 write transaction count", txn_count, 3);

    // R4 read mode, bus data ignored
    bus(1, A_CTRL, 16'h0001, rd, w);
    bus(1, enc(4, 7, 31), 16'hFFFF, rd, w);
    bus(0, A_DATA, 0, rd, w); check(rd == 16'hBEEF, "R4 read back phy4 p7 r31", rd, 16'hBEEF);
    bus(1, enc(1, 5, 9), 16'hAAAA, rd, w);
    bus(0, A_DATA, 0, rd, w); check(rd == ref_data, "R4 read phy1 p5 r9", rd, ref_data);

    // R5 ignored encodings, R8 data unchanged
    idle_wait();
    t0 = txn_count;
    bus(1, 16'h8003, 16'h1, rd, w);
    bus(1, 16'h8600, 16'h2, rd, w);
    bus(1, enc(1, 0, 2) | 16'h0100, 16'h3, rd, w);
    bus(1, 16'hC005, 16'h4, rd, w);
    bus(1, enc(2, 0, 0) & 16'h7FFF, 16'h5, rd, w);
    check(w < 1000, "R5 invalid address acknowledged", w, 0);
    repeat (3) @(negedge clk);
    check(txn_count == t0, "R5 no transaction for bad patterns", txn_count, t0);
    bus(0, A_DATA, 0, rd, w); check(rd == ref_data, "R8 data kept after ignored", rd, ref_data);

    // R7 stall of data read behind a pending fetch
    lat = 8;
    bus(1, enc(3, 2, 6), 16'h0, rd, w);
    bus(0, A_DATA, 0, rd, w);
    check(w >= 8, "R7 data read stalled", w, 8);
    check(rd == phy_mem[3][2][6], "R7 stalled read returns fresh data", rd, phy_mem[3][2][6]);
    lat = 5;
    bus(1, enc(0, 1, 1), 16'h0, rd, w);
    bus(0, A_CTRL, 0, rd, w);
    check(w >= 5 && rd == 16'h1, "R7 ctrl read stalled", {w[15:0], rd}, {16'd5, 16'h1});
    lat = 1;

    // R8 data register holds through writes
    bus(0, A_DATA, 0, rd, w);
    t0 = rd;
    bus(1, A_CTRL, 16'h0000, rd, w);
    bus(1, enc(3, 2, 6), 16'h7777, rd, w);
    bus(0, A_DATA, 0, rd, w); check(rd == t0[15:0], "R8 unchanged by write txn", rd, t0);
    bus(1, A_DATA, 16'h1111, rd, w);
    bus(0, A_DATA, 0, rd, w); check(rd == t0[15:0], "R8 write to data reg ignored", rd, t0);
    bus(1, A_CTRL, 16'h0001, rd, w);
    bus(1, enc(3, 2, 6), 16'h0, rd, w);
    bus(0, A_DATA, 0, rd, w); check(rd == 16'h7777, "R3 write landed in PHY", rd, 16'h7777);

    // R9 other addresses
    idle_wait();
    t0 = txn_count;
    bus(0, 16'h1234, 0, rd, w); check(rd == 0, "R9 other address reads 0", rd, 0);
    bus(0, enc(0, 0, 1), 0, rd, w); check(rd == 0, "R9 read of encoded address", rd, 0);
    bus(1, 16'h0042, 16'hFFFF, rd, w);
    bus(0, A_CTRL, 0, rd, w); check(rd == 16'h1, "R9 stray write no effect", rd, 1);
    repeat (3) @(negedge clk);
    check(txn_count == t0, "R9 no transaction from reads", txn_count, t0);
    @(negedge clk);
    check(hst_ack == 1'b0, "R9 ack is a pulse", hst_ack, 0);

    finish_run();
  end
endmodule